// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block predicts the direction of conditional branches at fetch time. It holds a table of 2^K two-bit saturating counters. Each counter is selected by the word-address bits of the instruction address, which are the K bits just above the two byte-offset bits. A lookup port takes the fetch address and reads the selected counter. The top bit of that counter gives a taken or not-taken prediction in the same cycle. The fetch stage also supplies two pieces of decode information: a flag that marks the instruction as a branch, and its sign-extended offset. From these the block forms the predicted next fetch address, which is either the branch target (address plus offset) or the sequential address (address plus four).

Once a branch resolves, the execute stage drives the update port with the branch address and its actual direction. On the next clock edge the selected counter moves one step toward that direction and stops at the end of its range. Several counter states lie between the two extremes, so one surprising outcome does not flip a prediction that has already been confirmed twice.

Top module: `bht_predictor`

## Requirements
- R1: An update with outcome taken adds one to the selected counter, and a counter already at 2'b11 stays at 2'b11.
- R2: An update with outcome not taken subtracts one from the selected counter, and a counter already at 2'b00 stays at 2'b00.
- R3: Counter encoding: 2'b11 is strongly taken, 2'b10 is weakly taken, 2'b01 is weakly not taken and 2'b00 is strongly not taken. `lk_taken` is 1 exactly when the selected counter's upper bit is 1.
- R4: After reset, every counter holds 2'b01, so every lookup predicts not taken.
- R5: The counter index is address bits [K+1:2]. Bits [1:0] and bits above K+1 do not select the counter, so two addresses that differ by 4·2^K share one counter.
- R6: When `lk_is_branch` is 1 and the prediction is taken, `lk_next_pc` equals `lk_pc + lk_offset`, with 32-bit wraparound.
- R7: When `lk_is_branch` is 0, or the prediction is not taken, `lk_next_pc` equals `lk_pc + 4`. This holds even when the counter predicts taken.
- R8: When a lookup and an update select the same counter in one cycle, the lookup returns the value from before the update. The new value is visible from the next cycle.
- R9: An update changes only the counter it selects. While `up_valid` is 0, no counter changes, whatever `up_taken` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | AW | Fetch address to predict |
| lk_is_branch | input | 1 | Decode marks the fetched instruction as a branch |
| lk_offset | input | AW | Sign-extended branch offset |
| lk_taken | output | 1 | Predicted direction (1 = taken) |
| lk_next_pc | output | AW | Predicted next fetch address |
| up_valid | input | 1 | Resolved-branch update strobe |
| up_pc | input | AW | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
Runs of taken updates followed by runs of not-taken updates take one counter through all four states and past both ends. This shows whether the counter saturates or wraps, and whether a single opposite outcome is absorbed or flips the prediction. Next-PC checks use a branch with a negative offset, a non-branch whose counter predicts taken, and a branch predicted not taken, which separates the target path from the sequential path. Address patterns that differ only in bits [1:0], in bits above the index, or by one word show which bits select a counter and whether neighbouring counters stay untouched. A lookup and an update on the same counter in one cycle show whether the read returns the value from before the write.

// File: rtl/bht_pkg.sv
package bht_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_e;

    localparam logic [1:0] CTR_RESET = CTR_WEAK_NT;
    localparam int unsigned BYTE_OFS_BITS = 2;
    localparam int unsigned INSTR_BYTES   = 4;

endpackage

// File: rtl/bht_ctr_step.sv
module bht_ctr_step
    import bht_pkg::*;
(
    input  logic [1:0] cur,
    input  logic       taken,
    output logic [1:0] nxt
);

    always_comb begin
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T) nxt = cur + 2'd1;
        end else begin
            if (cur != CTR_STRONG_NT) nxt = cur - 2'd1;
        end
    end

endmodule

// File: rtl/bht_table.sv
module bht_table
    import bht_pkg::*;
#(
    parameter int unsigned K = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [K-1:0] rd_idx,
    output logic [1:0]   rd_ctr,
    input  logic         wr_en,
    input  logic [K-1:0] wr_idx,
    input  logic         wr_taken
);

    localparam int unsigned N = 1 << K;

    typedef struct packed {
        logic [N-1:0][1:0] ctr;
    } tbl_t;

    tbl_t       st_d, st_q;
    logic [1:0] step_val;

    bht_ctr_step u_step (
        .cur   (st_q.ctr[wr_idx]),
        .taken (wr_taken),
        .nxt   (step_val)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.ctr[wr_idx] = step_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= {N{CTR_RESET}};
        else        st_q <= st_d;
    end

    // Read the registered array: a same-cycle write is visible only after the edge.
    assign rd_ctr = st_q.ctr[rd_idx];

    p_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && st_q.ctr[wr_idx] != 2'b11)
        |=> st_q.ctr[$past(wr_idx)] == $past(st_q.ctr[wr_idx]) + 2'd1);

    p_hold_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && st_q.ctr[wr_idx] == 2'b11)
        |=> st_q.ctr[$past(wr_idx)] == 2'b11);

    p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && st_q.ctr[wr_idx] != 2'b00)
        |=> st_q.ctr[$past(wr_idx)] == $past(st_q.ctr[wr_idx]) - 2'd1);

    p_hold_bot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && st_q.ctr[wr_idx] == 2'b00)
        |=> st_q.ctr[$past(wr_idx)] == 2'b00);

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> st_q == $past(st_q));

endmodule

// File: rtl/bht_next_pc.sv
module bht_next_pc
    import bht_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] offset,
    input  logic          is_branch,
    input  logic          pred_taken,
    output logic [AW-1:0] next_pc
);

    logic [AW-1:0] seq_pc_d, tgt_pc_d;

    always_comb begin
        seq_pc_d = pc + AW'(INSTR_BYTES);
        tgt_pc_d = pc + offset;
        next_pc  = (is_branch && pred_taken) ? tgt_pc_d : seq_pc_d;
    end

endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
    import bht_pkg::*;
#(
    parameter int unsigned K  = 10,
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] lk_pc,
    input  logic          lk_is_branch,
    input  logic [AW-1:0] lk_offset,
    output logic          lk_taken,
    output logic [AW-1:0] lk_next_pc,
    input  logic          up_valid,
    input  logic [AW-1:0] up_pc,
    input  logic          up_taken
);

    localparam int unsigned IDX_LO = BYTE_OFS_BITS;
    localparam int unsigned IDX_HI = IDX_LO + K - 1;

    logic [K-1:0] lk_idx, up_idx;
    logic [1:0]   lk_ctr;

    assign lk_idx   = lk_pc[IDX_HI:IDX_LO];
    assign up_idx   = up_pc[IDX_HI:IDX_LO];
    assign lk_taken = lk_ctr[1];

    bht_table #(.K(K)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_ctr   (lk_ctr),
        .wr_en    (up_valid),
        .wr_idx   (up_idx),
        .wr_taken (up_taken)
    );

    bht_next_pc #(.AW(AW)) u_npc (
        .pc         (lk_pc),
        .offset     (lk_offset),
        .is_branch  (lk_is_branch),
        .pred_taken (lk_taken),
        .next_pc    (lk_next_pc)
    );

    p_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_is_branch && lk_taken) |-> lk_next_pc == lk_pc + lk_offset);

    p_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_is_branch || !lk_taken) |-> lk_next_pc == lk_pc + AW'(INSTR_BYTES));

    p_same_idx_old_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && lk_idx == up_idx && lk_ctr == 2'b01
         && $stable(lk_pc))
        |=> lk_taken);

endmodule

// File: tb/test_bht_predictor.sv
`timescale 1ns/1ps
module test_bht_predictor;

    localparam int K  = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] lk_pc, lk_offset, up_pc, lk_next_pc;
    logic          lk_is_branch, lk_taken, up_valid, up_taken;

    int vectors = 0;
    int fails   = 0;

    always #2.5 clk = ~clk;

    bht_predictor #(.K(K), .AW(AW)) i_bht_predictor (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_pc        (lk_pc),
        .lk_is_branch (lk_is_branch),
        .lk_offset    (lk_offset),
        .lk_taken     (lk_taken),
        .lk_next_pc   (lk_next_pc),
        .up_valid     (up_valid),
        .up_pc        (up_pc),
        .up_taken     (up_taken)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic update(input logic [31:0] pc, input logic tk);
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_taken = tk;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic probe(input logic [31:0] pc, input logic br, input logic [31:0] ofs);
        lk_pc = pc; lk_is_branch = br; lk_offset = ofs;
        #0.5;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 4; i++) begin
            probe(32'h1000 + 32'(i) * 32'h44, 1'b1, 32'h80);
            check("R4 reset predicts not taken", {31'd0, lk_taken}, 32'd0);
            check("R7 reset next pc sequential", lk_next_pc, lk_pc + 32'd4);
        end
    endtask

    task automatic t_count_up;
        logic [31:0] a;
        a = 32'h0000_2000;
        update(a, 1'b1);
        probe(a, 1'b1, 32'h40);
        check("R3 weak taken 10 predicts taken", {31'd0, lk_taken}, 32'd1);
        check("R6 taken branch target", lk_next_pc, a + 32'h40);
        for (int i = 0; i < 4; i++) update(a, 1'b1);
        update(a, 1'b0);
        probe(a, 1'b1, 32'h40);
        check("R1 saturate at 11 then one not-taken still taken", {31'd0, lk_taken}, 32'd1);
        update(a, 1'b0);
        probe(a, 1'b1, 32'h40);
        check("R1 two not-taken from 11 reach 01", {31'd0, lk_taken}, 32'd0);
    endtask

    task automatic t_count_down;
        logic [31:0] a;
        a = 32'h0000_3010;
        for (int i = 0; i < 5; i++) update(a, 1'b0);
        update(a, 1'b1);
        probe(a, 1'b1, 32'h20);
        check("R2 clamp at 00 then one taken gives 01", {31'd0, lk_taken}, 32'd0);
        update(a, 1'b1);
        probe(a, 1'b1, 32'h20);
        check("R2 second taken gives 10", {31'd0, lk_taken}, 32'd1);
    endtask

    task automatic t_next_pc;
        logic [31:0] a;
        a = 32'h0000_4100;
        update(a, 1'b1);
        update(a, 1'b1);
        probe(a, 1'b1, 32'hFFFF_FFF0);
        check("R6 negative offset target", lk_next_pc, a - 32'h10);
        probe(a, 1'b0, 32'hFFFF_FFF0);
        check("R7 non-branch with taken counter", lk_next_pc, a + 32'd4);
        check("R3 lk_taken independent of is_branch", {31'd0, lk_taken}, 32'd1);
        probe(32'h0000_4104, 1'b1, 32'h100);
        check("R7 branch predicted not taken", lk_next_pc, 32'h0000_4108);
    endtask

    task automatic t_alias;
        logic [31:0] a;
        a = 32'h0000_0200;
        update(a | 32'h3, 1'b1);
        probe(a, 1'b1, 32'h8);
        check("R5 low bits ignored", {31'd0, lk_taken}, 32'd1);
        probe(a + (32'd4 << K), 1'b1, 32'h8);
        check("R5 upper bits alias", {31'd0, lk_taken}, 32'd1);
        probe(a + 32'd4, 1'b1, 32'h8);
        check("R9 neighbour untouched", {31'd0, lk_taken}, 32'd0);
        probe(a - 32'd4, 1'b1, 32'h8);
        check("R9 lower neighbour untouched", {31'd0, lk_taken}, 32'd0);
    endtask

    task automatic t_collision;
        logic [31:0] a;
        a = 32'h0000_0500;
        @(negedge clk);
        probe(a, 1'b1, 32'h10);
        up_valid = 1'b1; up_pc = a; up_taken = 1'b1;
        #0.5;
        check("R8 same-cycle lookup sees old value", {31'd0, lk_taken}, 32'd0);
        @(negedge clk);
        up_valid = 1'b0;
        #0.5;
        check("R8 new value visible next cycle", {31'd0, lk_taken}, 32'd1);
    endtask

    task automatic t_idle;
        logic [31:0] a;
        a = 32'h0000_0700;
        @(negedge clk);
        up_valid = 1'b0; up_pc = a; up_taken = 1'b1;
        repeat (3) @(negedge clk);
        probe(a, 1'b1, 32'h10);
        check("R9 no change while up_valid low", {31'd0, lk_taken}, 32'd0);
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; up_valid = 1'b0; up_pc = '0; up_taken = 1'b0;
        lk_pc = '0; lk_is_branch = 1'b0; lk_offset = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count_up();
        t_count_down();
        t_next_pc();
        t_alias();
        t_collision();
        t_idle();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule